// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small translation cache that sits beside an address translation unit. A lookup presents a virtual page number; one clock later the block reports whether a valid translation was present and, on a hit, returns the physical page number and the access-rights bits that were stored with it. When a lookup misses, the translation unit walks the page table elsewhere and hands the finished entry back through the fill port. A flush input drops every stored translation at once, which is what a context switch needs.

With the default parameters, virtual addresses are 14 bits and pages are 64 bytes, so the virtual page number (VPN) is address bits [13:6] and is 8 bits wide. The physical page number (PPN) is 6 bits. Storage is 16 entries arranged as 4 sets of 4 ways. The low VPN bits choose the set and the remaining VPN bits are compared as the tag against every way of that set in parallel. A fill goes first to a way that already holds the same tag, then to the lowest-numbered empty way, and otherwise to the way named by a round-robin pointer that each set keeps for itself.

The response is driven by a three-state machine. The states are `RSP_IDLE` (no response this cycle), `RSP_HIT` (valid response, hit) and `RSP_MISS` (valid response, miss). From any state the machine moves to `RSP_HIT` when a lookup is presented, flush is low, and a valid way of the selected set matches. It moves to `RSP_MISS` when a lookup is presented and either no way matches or flush is high. It moves to `RSP_IDLE` when no lookup is presented.

Top module: `xlat_cache`

## Requirements
- R1: The set index is VPN bits [1:0] and the tag is VPN bits [7:2]. An entry only hits a lookup whose VPN has both the same set index and the same tag.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high, and is low otherwise. Back-to-back lookups each get their own response.
- R3: A lookup hits when a valid way of the selected set holds the tag. The response then gives that way's stored PPN and rights unchanged. The rights encoding is bit 0 = read, bit 1 = write, bit 2 = execute.
- R4: On a miss, `rsp_hit` is 0 and both `rsp_ppn` and `rsp_rights` are 0.
- R5: After reset no entry is valid, and `rsp_valid` is low while reset is held.
- R6: A fill whose tag is not already in the set writes the lowest-numbered invalid way, if there is one. It does not use the round-robin pointer in that case.
- R7: When every way of the target set is valid and the tag is new, the fill replaces the way named by that set's round-robin pointer. The pointer starts at way 0 after reset, advances by one (wrapping) after each such replacement, is separate for each set, and is not changed by flush.
- R8: A fill whose tag already sits valid in the target set overwrites that way in place. Nothing is evicted and the pointer does not move. No two valid ways of a set ever share a tag.
- R9: Flush clears every valid bit in one cycle. A lookup made in the flush cycle, or after it, misses. A fill made in the flush cycle is discarded.
- R10: A lookup made in the same cycle as a fill sees the contents as they were before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 8 | VPN to look up |
| fill_req | input | 1 | Write one translation |
| fill_vpn | input | 8 | VPN of the translation being written |
| fill_ppn | input | 6 | PPN of the translation being written |
| fill_rights | input | 3 | Rights of the translation (bit0 read, bit1 write, bit2 execute) |
| flush | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present (one cycle after `lk_req`) |
| rsp_hit | output | 1 | Lookup found a valid matching entry |
| rsp_ppn | output | 6 | PPN on a hit, 0 on a miss |
| rsp_rights | output | 3 | Rights on a hit, 0 on a miss |

## Verification
The bench builds the block with its default parameters: a 14-bit virtual address, 64-byte pages, 4 sets of 4 ways and 3 rights bits. With only four ways per set, the bench can fill a set completely in a few operations and then step the replacement pointer across several evictions. That lets it tell the empty-way-first choice apart from a pure pointer choice by the order in which entries disappear after a flush. The 8-bit VPN also lets the bench use literal address examples, such as 0x03D4 hitting set 3 and 0x028F missing in set 2.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Response state of the lookup pipeline
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/xlat_set.sv
// One set: tag/PPN/rights storage per way, parallel tag compare,
// victim choice (same tag, then lowest free way, then round-robin).
module xlat_set #(
    parameter int TAG_W    = 6,
    parameter int PPN_W    = 6,
    parameter int RIGHTS_W = 3,
    parameter int WAYS     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [TAG_W-1:0]    lk_tag,
    input  logic                fill_en,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [RIGHTS_W-1:0] fill_rights,
    output logic [WAYS-1:0]     lk_match,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic [RIGHTS_W-1:0] lk_rights
);

    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAYS-1:0]     valid_q;
    logic [TAG_W-1:0]    tag_q    [WAYS];
    logic [PPN_W-1:0]    ppn_q    [WAYS];
    logic [RIGHTS_W-1:0] rights_q [WAYS];
    logic [WAY_W-1:0]    rr_q;

    logic [WAYS-1:0]     fill_match;
    logic [WAY_W-1:0]    victim;
    logic [WAY_W-1:0]    match_way;
    logic [WAY_W-1:0]    free_way;
    logic                use_rr;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_match[w]   = valid_q[w] && (tag_q[w] == lk_tag);
        assign fill_match[w] = valid_q[w] && (tag_q[w] == fill_tag);
    end

    // Lowest-numbered matching way drives the read data
    always_comb begin
        lk_ppn    = '0;
        lk_rights = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) begin
                lk_ppn    = ppn_q[w];
                lk_rights = rights_q[w];
            end
        end
    end

    // Victim selection for a fill
    always_comb begin
        match_way = '0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (fill_match[w]) match_way = WAY_W'(w);
            if (!valid_q[w])   free_way  = WAY_W'(w);
        end
        use_rr = 1'b0;
        if (|fill_match) begin
            victim = match_way;
        end else if (!(&valid_q)) begin
            victim = free_way;
        end else begin
            victim = rr_q;
            use_rr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[victim] <= 1'b1;
            if (use_rr) begin
                rr_q <= (rr_q == LAST_WAY) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[victim]    <= fill_tag;
            ppn_q[victim]    <= fill_ppn;
            rights_q[victim] <= fill_rights;
        end
    end

endmodule

// File: rtl/xlat_ctl.sv
// Response state machine: one cycle after each lookup it reports hit or miss.
module xlat_ctl
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_req,
    input  logic lk_hit,
    output logic rsp_valid,
    output logic rsp_hit
);

    rsp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!lk_req)     state_d = RSP_IDLE;
        else if (lk_hit) state_d = RSP_HIT;
        else             state_d = RSP_MISS;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
            RSP_HIT:  begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            RSP_MISS: begin rsp_valid = 1'b1; rsp_hit = 1'b0; end
            default:  begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
        endcase
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int VA_W     = 14,
    parameter int PA_W     = 12,
    parameter int OFS_W    = 6,
    parameter int SETS     = 4,
    parameter int WAYS     = 4,
    parameter int RIGHTS_W = 3,
    localparam int VPN_W   = VA_W - OFS_W,
    localparam int PPN_W   = PA_W - OFS_W,
    localparam int IDX_W   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int TAG_W   = VPN_W - IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_req,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic                fill_req,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [RIGHTS_W-1:0] fill_rights,
    input  logic                flush,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [PPN_W-1:0]    rsp_ppn,
    output logic [RIGHTS_W-1:0] rsp_rights
);

    logic [IDX_W-1:0]    lk_idx, fill_idx;
    logic [TAG_W-1:0]    lk_tag, fill_tag;
    logic [WAYS-1:0]     set_match  [SETS];
    logic [PPN_W-1:0]    set_ppn    [SETS];
    logic [RIGHTS_W-1:0] set_rights [SETS];
    logic [WAYS-1:0]     sel_match;
    logic                hit_now;
    logic [PPN_W-1:0]    ppn_q;
    logic [RIGHTS_W-1:0] rights_q;

    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic fill_here;
        assign fill_here = fill_req && !flush && (fill_idx == IDX_W'(s));
        xlat_set #(
            .TAG_W    (TAG_W),
            .PPN_W    (PPN_W),
            .RIGHTS_W (RIGHTS_W),
            .WAYS     (WAYS)
        ) u_set (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush       (flush),
            .lk_tag      (lk_tag),
            .fill_en     (fill_here),
            .fill_tag    (fill_tag),
            .fill_ppn    (fill_ppn),
            .fill_rights (fill_rights),
            .lk_match    (set_match[s]),
            .lk_ppn      (set_ppn[s]),
            .lk_rights   (set_rights[s])
        );
    end

    assign sel_match = set_match[lk_idx];
    assign hit_now   = (|sel_match) && !flush;

    xlat_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_hit    (hit_now),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ppn_q    <= '0;
            rights_q <= '0;
        end else if (lk_req && hit_now) begin
            ppn_q    <= set_ppn[lk_idx];
            rights_q <= set_rights[lk_idx];
        end else begin
            ppn_q    <= '0;
            rights_q <= '0;
        end
    end

    assign rsp_ppn    = ppn_q;
    assign rsp_rights = rights_q;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int PPN_W    = 6,
    parameter int RIGHTS_W = 3,
    parameter int WAYS     = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_req,
    input logic                flush,
    input logic [WAYS-1:0]     sel_match,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic [PPN_W-1:0]    rsp_ppn,
    input logic [RIGHTS_W-1:0] rsp_rights
);

    // R2
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_rights == '0));

    // R3
    no_match_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && sel_match == '0) |=> !rsp_hit);

    // R8
    dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> ($countones(sel_match) <= 1));

    // R9
    flush_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && flush) |=> !rsp_hit);

    // R9
    flush_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 lk_req) |=> !rsp_hit);

endmodule

bind xlat_cache xlat_cache_chk #(
    .PPN_W    (PPN_W),
    .RIGHTS_W (RIGHTS_W),
    .WAYS     (WAYS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_req     (lk_req),
    .flush      (flush),
    .sel_match  (sel_match),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_ppn    (rsp_ppn),
    .rsp_rights (rsp_rights)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_req = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic       fill_req = 1'b0;
    logic [7:0] fill_vpn = '0;
    logic [5:0] fill_ppn = '0;
    logic [2:0] fill_rights = '0;
    logic       flush = 1'b0;
    logic       rsp_valid, rsp_hit;
    logic [5:0] rsp_ppn;
    logic [2:0] rsp_rights;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rights(fill_rights), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ppn(rsp_ppn), .rsp_rights(rsp_rights)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input bit hit, input int ppn, input int rights);
        chk(req, "rsp_valid", int'(rsp_valid), 1);
        chk(req, "rsp_hit", int'(rsp_hit), int'(hit));
        chk(req, "rsp_ppn", int'(rsp_ppn), hit ? ppn : 0);
        chk(req, "rsp_rights", int'(rsp_rights), hit ? rights : 0);
    endtask

    task automatic do_fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic [2:0] r);
        @(negedge clk);
        fill_req = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = r;
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    task automatic do_look(input logic [7:0] vpn, input bit hit, input int ppn,
                           input int rights, input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = vpn;
        @(negedge clk);
        lk_req = 1'b0;
        check_rsp(req, hit, ppn, rights);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // R5: reset state
    task automatic t_reset();
        chk("R5", "rsp_valid in reset", int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        do_look(8'h0F, 1'b0, 0, 0, "R5");
        @(negedge clk);
        chk("R2", "rsp_valid idle", int'(rsp_valid), 0);
    endtask

    // R1/R3/R4: address split, hit data, miss zeros
    task automatic t_example();
        do_fill(8'h0F, 6'h0D, 3'b011);
        do_look(8'(14'h03D4 >> 6), 1'b1, 'h0D, 3, "R3");
        do_look(8'(14'h028F >> 6), 1'b0, 0, 0, "R4");
        do_look(8'h0E, 1'b0, 0, 0, "R1");
        do_look(8'h4F, 1'b0, 0, 0, "R1");
    endtask

    // R6/R7: fill order, round-robin eviction, per-set pointers
    task automatic t_rr();
        do_fill(8'h05, 6'h01, 3'b001);
        do_fill(8'h09, 6'h02, 3'b010);
        do_fill(8'h0D, 6'h03, 3'b100);
        do_fill(8'h11, 6'h04, 3'b111);
        do_look(8'h05, 1'b1, 'h01, 1, "R6");
        do_look(8'h09, 1'b1, 'h02, 2, "R6");
        do_look(8'h0D, 1'b1, 'h03, 4, "R6");
        do_look(8'h11, 1'b1, 'h04, 7, "R6");
        do_fill(8'h15, 6'h05, 3'b001);
        do_look(8'h05, 1'b0, 0, 0, "R7");
        do_look(8'h15, 1'b1, 'h05, 1, "R7");
        do_fill(8'h19, 6'h06, 3'b011);
        do_look(8'h09, 1'b0, 0, 0, "R7");
        do_look(8'h0D, 1'b1, 'h03, 4, "R7");
        do_look(8'h19, 1'b1, 'h06, 3, "R7");
        // set 2 has its own pointer starting at way 0
        do_fill(8'h06, 6'h21, 3'b001);
        do_fill(8'h0A, 6'h22, 3'b001);
        do_fill(8'h0E, 6'h23, 3'b001);
        do_fill(8'h12, 6'h24, 3'b001);
        do_fill(8'h16, 6'h25, 3'b001);
        do_look(8'h06, 1'b0, 0, 0, "R7");
        do_look(8'h0A, 1'b1, 'h22, 1, "R7");
    endtask

    // R8: refill of a present tag replaces in place
    task automatic t_refill();
        do_fill(8'h11, 6'h2A, 3'b101);
        do_look(8'h11, 1'b1, 'h2A, 5, "R8");
        do_look(8'h0D, 1'b1, 'h03, 4, "R8");
        do_look(8'h15, 1'b1, 'h05, 1, "R8");
        do_look(8'h19, 1'b1, 'h06, 3, "R8");
    endtask

    // R9 then R6: flush empties everything; empty ways are used before the pointer
    task automatic t_flush_then_free();
        do_flush();
        do_look(8'h0F, 1'b0, 0, 0, "R9");
        do_look(8'h11, 1'b0, 0, 0, "R9");
        do_look(8'h0A, 1'b0, 0, 0, "R9");
        do_fill(8'h21, 6'h10, 3'b001);
        do_fill(8'h25, 6'h11, 3'b001);
        do_fill(8'h29, 6'h12, 3'b001);
        do_fill(8'h2D, 6'h13, 3'b001);
        do_fill(8'h31, 6'h14, 3'b010);
        do_look(8'h29, 1'b0, 0, 0, "R6");
        do_look(8'h21, 1'b1, 'h10, 1, "R6");
        do_look(8'h31, 1'b1, 'h14, 2, "R7");
    endtask

    // R9: lookup and fill in the flush cycle
    task automatic t_flush_concurrent();
        do_fill(8'h03, 6'h20, 3'b111);
        @(negedge clk);
        flush = 1'b1;
        lk_req = 1'b1; lk_vpn = 8'h03;
        fill_req = 1'b1; fill_vpn = 8'h07; fill_ppn = 6'h30; fill_rights = 3'b001;
        @(negedge clk);
        flush = 1'b0; lk_req = 1'b0; fill_req = 1'b0;
        check_rsp("R9", 1'b0, 0, 0);
        do_look(8'h07, 1'b0, 0, 0, "R9");
        do_look(8'h03, 1'b0, 0, 0, "R9");
    endtask

    // R10: lookup in the fill cycle sees old contents
    task automatic t_same_cycle();
        @(negedge clk);
        fill_req = 1'b1; fill_vpn = 8'h3B; fill_ppn = 6'h15; fill_rights = 3'b110;
        lk_req = 1'b1; lk_vpn = 8'h3B;
        @(negedge clk);
        fill_req = 1'b0; lk_req = 1'b0;
        check_rsp("R10", 1'b0, 0, 0);
        do_look(8'h3B, 1'b1, 'h15, 6, "R10");
    endtask

    // R2: back-to-back lookups, plus largest VPN and PPN values (R3)
    task automatic t_b2b();
        do_fill(8'hFF, 6'h3F, 3'b111);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = 8'hFF;
        @(negedge clk);
        lk_vpn = 8'hFB;
        check_rsp("R2", 1'b1, 'h3F, 7);
        @(negedge clk);
        lk_req = 1'b0;
        check_rsp("R2", 1'b0, 0, 0);
        @(negedge clk);
        chk("R2", "rsp_valid after burst", int'(rsp_valid), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_example();
        t_rr();
        t_refill();
        t_flush_then_free();
        t_flush_concurrent();
        t_same_cycle();
        t_b2b();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule